// File: doc/BRIEF.md
# Two-Pass Password Verifier with Attempts Counters

This block checks 24-bit passwords that a host presents against four stored values. The four values are a read password and a write password for each of two sets. The write password of set 1 also serves as the secure code. Each stored password has its own 8-bit attempts counter. The counter is kept as a thermometer of cleared bits.

Verification always takes two commands issued back to back for the same password. The first command is an initialization pass: it clears one counter bit and ignores the data it carries. The second command compares the data with the stored value. A match restores the counter to all ones and makes that password the active one. A mismatch leaves the cleared bit in place. Once every counter bit in use has been cleared, further presentations of that password have no effect.

The block tells a downstream access checker which single password is currently active. It accepts one command per start pulse and reports the updated counter value with a one-cycle done pulse. The stored passwords come from a register file outside the block.

Top module: `pw_verifier`

## Requirements
- R1: After reset no password is active (`act_valid_o`=0, `secure_o`=0), `busy_o` and `done_o` are 0, and every attempts counter holds 0xFF.
- R2: A command whose selection does not match an armed initialization pass is an initialization pass. It clears the lowest-index counter bit that is still 1 within the bits in use, arms that selection and reports the new counter on `pac_o`. Its password data has no effect on any output.
- R3: A command that immediately follows an initialization pass of the same selection, with data equal to the stored password, sets the counter to 0xFF and makes that selection active (`act_valid_o`=1, `act_id_o`=selection).
- R4: If that compare pass has data that differs from the stored password, the counter keeps its cleared bit and no password is active.
- R5: A compare pass, whatever its result, disarms the selection. An initialization pass of a different selection re-arms to the new one. In both cases the next command is an initialization pass.
- R6: When `ext_trials_ni`=1 only counter bits 3:0 are in use (four trials). Once they are all 0, an initialization pass for that password is ignored: no counter, arming or active-state change, and `pac_o` reports the unchanged counter.
- R7: When `ext_trials_ni`=0 all 8 counter bits are in use, allowing eight trials before lock-out.
- R8: At most one password is active. Any accepted initialization pass or failed compare clears `act_valid_o`, and the active state changes only in the cycle in which `done_o` is 1.
- R9: `secure_o` is 1 exactly when `act_valid_o`=1 and the active selection is 2'b01 (write password of set 1).
- R10: A `start_i` seen while `busy_o`=0 is accepted. `busy_o` is 1 in the following cycle and `done_o` is 1 for exactly one cycle after that. A `start_i` seen while `busy_o`=1 is ignored.
- R11: Each of the four counters is independent: commands on one selection never change another selection's counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command strobe |
| sel_i | input | 2 | Selection {r,p}: bit 1 = r (0 write, 1 read), bit 0 = p (set number) |
| pw_i | input | 24 | Presented password, three bytes |
| ext_trials_ni | input | 1 | 0 selects eight trials, 1 selects four trials |
| stored_pw_i | input | 96 | Stored passwords; slot k is bits [24k+23:24k], with k = {r,p} |
| busy_o | output | 1 | Command being evaluated |
| done_o | output | 1 | One-cycle completion pulse |
| pac_o | output | 8 | Counter of the last command's selection after its update |
| act_valid_o | output | 1 | A password is currently active |
| act_id_o | output | 2 | Selection of the active password |
| secure_o | output | 1 | The active password is the secure code |

## Verification
For each of the four selections and both trial modes, the bench runs a full sweep of wrong attempts until lock-out. This tells a correct thermometer depth apart from an off-by-one or a wrong trial width, and shows that a locked password ignores commands. A second pattern places a correct compare after an increasing number of failures, and so separates the restore to 0xFF from plain bit clearing. Interleaved selections, a repeated compare and an initialization pass carrying correct data distinguish real two-pass pairing from a check on data alone. A start held over two cycles shows that a command is not taken twice.

// File: rtl/pwv_pkg.sv
package pwv_pkg;
  localparam int unsigned N_PW  = 4;
  localparam int unsigned SEL_W = 2;
  localparam logic [SEL_W-1:0] SECURE_SEL = 2'b01;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_INIT = 2'd1,
    ACT_CMP  = 2'd2
  } act_e;
endpackage

// File: rtl/pwv_pac_next.sv
module pwv_pac_next #(
  parameter int unsigned PAC_W      = 8,
  parameter int unsigned FEW_TRIALS = 4
) (
  input  logic [PAC_W-1:0] cur_i,
  input  logic             ext_trials_ni,
  output logic [PAC_W-1:0] next_o,
  output logic             locked_o
);
  localparam logic [PAC_W-1:0] FEW_MASK = {PAC_W{1'b1}} >> (PAC_W - FEW_TRIALS);

  logic [PAC_W-1:0] mask, live, low;

  always_comb begin
    mask     = ext_trials_ni ? FEW_MASK : {PAC_W{1'b1}};
    live     = cur_i & mask;
    low      = live & (~live + 1'b1);   // isolate lowest still-set bit
    next_o   = cur_i & ~low;
    locked_o = (live == '0);
  end
endmodule

// File: rtl/pwv_pac_bank.sv
module pwv_pac_bank
  import pwv_pkg::*;
#(
  parameter int unsigned PAC_W = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [SEL_W-1:0]            wr_idx_i,
  input  logic [PAC_W-1:0]            wr_val_i,
  output logic [N_PW-1:0][PAC_W-1:0]  cnt_o
);
  for (genvar g = 0; g < N_PW; g++) begin : g_cnt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  cnt_o[g] <= '1;
      else if (wr_en_i && wr_idx_i == SEL_W'(g))    cnt_o[g] <= wr_val_i;
    end
  end
endmodule

// File: rtl/pwv_session.sv
module pwv_session
  import pwv_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  act_e             act_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             match_i,
  output logic             is_cmp_o,
  output logic             valid_o,
  output logic [SEL_W-1:0] id_o
);
  logic             armed_q;
  logic [SEL_W-1:0] asel_q;

  assign is_cmp_o = armed_q && (asel_q == sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      asel_q  <= '0;
      valid_o <= 1'b0;
      id_o    <= '0;
    end else begin
      unique case (act_i)
        ACT_INIT: begin
          armed_q <= 1'b1;
          asel_q  <= sel_i;
          valid_o <= 1'b0;
        end
        ACT_CMP: begin
          armed_q <= 1'b0;
          valid_o <= match_i;
          if (match_i) id_o <= sel_i;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pw_verifier.sv
module pw_verifier
  import pwv_pkg::*;
#(
  parameter int unsigned PW_BYTES   = 3,
  parameter int unsigned PAC_W      = 8,
  parameter int unsigned FEW_TRIALS = 4,
  localparam int unsigned PW_W      = 8 * PW_BYTES
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [1:0]             sel_i,
  input  logic [PW_W-1:0]        pw_i,
  input  logic                   ext_trials_ni,
  input  logic [4*PW_W-1:0]      stored_pw_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic [PAC_W-1:0]       pac_o,
  output logic                   act_valid_o,
  output logic [1:0]             act_id_o,
  output logic                   secure_o
);
  logic             busy_q, done_q;
  logic [SEL_W-1:0] sel_q;
  logic [PW_W-1:0]  pw_q;
  logic [PAC_W-1:0] pac_q;

  logic [N_PW-1:0][PAC_W-1:0] cnt;
  logic [PAC_W-1:0] cur, nxt, wr_val, rep_val;
  logic             locked, match, is_cmp, wr_en;
  act_e             act;

  // command capture stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sel_q  <= '0;
      pw_q   <= '0;
      pac_q  <= '1;
    end else begin
      busy_q <= start_i && !busy_q;
      done_q <= busy_q;
      if (start_i && !busy_q) begin
        sel_q <= sel_i;
        pw_q  <= pw_i;
      end
      if (busy_q) pac_q <= rep_val;
    end
  end

  assign cur   = cnt[sel_q];
  assign match = (pw_q == stored_pw_i[sel_q*PW_W +: PW_W]);

  pwv_pac_next #(.PAC_W(PAC_W), .FEW_TRIALS(FEW_TRIALS)) i_next (
    .cur_i        (cur),
    .ext_trials_ni(ext_trials_ni),
    .next_o       (nxt),
    .locked_o     (locked)
  );

  always_comb begin
    if (!busy_q)     act = ACT_NONE;
    else if (is_cmp) act = ACT_CMP;
    else if (locked) act = ACT_NONE;   // lock-out applies to new passes only
    else             act = ACT_INIT;
    wr_en   = (act == ACT_INIT) || (act == ACT_CMP && match);
    wr_val  = (act == ACT_INIT) ? nxt : {PAC_W{1'b1}};
    rep_val = wr_en ? wr_val : cur;
  end

  pwv_pac_bank #(.PAC_W(PAC_W)) i_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en),
    .wr_idx_i(sel_q),
    .wr_val_i(wr_val),
    .cnt_o   (cnt)
  );

  pwv_session i_sess (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .act_i   (act),
    .sel_i   (sel_q),
    .match_i (match),
    .is_cmp_o(is_cmp),
    .valid_o (act_valid_o),
    .id_o    (act_id_o)
  );

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign pac_o    = pac_q;
  assign secure_o = act_valid_o && (act_id_o == SECURE_SEL);
endmodule

// File: rtl/pwv_checker.sv
module pwv_checker #(
  parameter int unsigned PAC_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [PAC_W-1:0] pac_o,
  input logic             act_valid_o
);
  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_busy_then_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> done_o && !busy_o);
  p_start_accept_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  p_valid_on_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_valid_o) |-> done_o);
  p_valid_pac_full_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_valid_o) |-> pac_o == {PAC_W{1'b1}});
endmodule

bind pw_verifier pwv_checker #(.PAC_W(PAC_W)) i_pwv_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .pac_o      (pac_o),
  .act_valid_o(act_valid_o)
);

// File: tb/test_pw_verifier.sv
`timescale 1ns/1ps
module test_pw_verifier;
  logic        clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, ext_trials_ni = 1'b1;
  logic [1:0]  sel_i = '0;
  logic [23:0] pw_i = '0;
  logic [95:0] stored_pw_i;
  logic        busy_o, done_o, act_valid_o, secure_o;
  logic [7:0]  pac_o;
  logic [1:0]  act_id_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // model state
  int       m_used[4];
  bit       m_armed, m_valid;
  bit [1:0] m_asel, m_id;

  always #5 clk_i = ~clk_i;

  function automatic logic [23:0] pw_of(int k);
    return {8'(8'h30 + k), 8'(8'hC0 ^ k), 8'(8'h5A + 3 * k)};
  endfunction

  for (genvar k = 0; k < 4; k++) begin : g_st
    assign stored_pw_i[24*k +: 24] = pw_of(k);
  end

  pw_verifier i_pw_verifier (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    foreach (m_used[k]) m_used[k] = 0;
    m_armed = 0; m_valid = 0; m_asel = 0; m_id = 0;
  endtask

  task automatic check_state(string req);
    chk({req, " pac"}, 32'(pac_o), 32'(8'(8'hFF << m_used[sel_i])));
    chk({req, " valid"}, 32'(act_valid_o), 32'(m_valid));
    if (m_valid) chk({req, " id"}, 32'(act_id_o), 32'(m_id));
    chk("R9 secure", 32'(secure_o), 32'(m_valid && m_id == 2'b01));
  endtask

  // one command; hold = 2 keeps start high a second cycle (must be ignored)
  task automatic do_cmd(bit [1:0] sel, logic [23:0] pw, string req, int hold = 1);
    int lim = ext_trials_ni ? 4 : 8;
    if (m_armed && m_asel == sel) begin
      m_armed = 0;
      if (pw == pw_of(sel)) begin m_used[sel] = 0; m_valid = 1; m_id = sel; end
      else m_valid = 0;
    end else if (m_used[sel] < lim) begin
      m_used[sel]++; m_armed = 1; m_asel = sel; m_valid = 0;
    end
    sel_i = sel; pw_i = pw; start_i = 1'b1;
    @(negedge clk_i);
    chk("R10 busy", 32'(busy_o), 32'd1);
    if (hold < 2) start_i = 1'b0;
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R10 done", 32'(done_o), 32'd1);
    check_state(req);
    @(negedge clk_i);
    chk("R10 done single", 32'(done_o), 32'd0);
    chk("R10 idle", 32'(busy_o), 32'd0);
  endtask

  initial begin
    do_reset();
    chk("R1 valid", 32'(act_valid_o), 32'd0);
    chk("R1 busy",  32'(busy_o), 32'd0);
    chk("R1 done",  32'(done_o), 32'd0);
    chk("R1 secure", 32'(secure_o), 32'd0);
    chk("R1 pac",   32'(pac_o), 32'hFF);

    // lock-out sweep, both trial modes, all selections
    for (int mode = 0; mode < 2; mode++) begin
      ext_trials_ni = (mode == 0);
      do_reset();
      for (int k = 0; k < 4; k++) begin
        int lim = ext_trials_ni ? 4 : 8;
        for (int t = 0; t < lim; t++) begin
          do_cmd(2'(k), 24'h0, mode == 0 ? "R2/R11 init" : "R7 init");
          do_cmd(2'(k), pw_of(k) ^ 24'h1, "R4 wrong");
        end
        do_cmd(2'(k), pw_of(k), "R6 locked ignored");
        do_cmd(2'(k), pw_of(k), "R6 locked again");
      end
    end

    // correct pass after w failures
    for (int mode = 0; mode < 2; mode++) begin
      ext_trials_ni = (mode == 0);
      for (int k = 0; k < 4; k++) begin
        int lim = ext_trials_ni ? 4 : 8;
        for (int w = 0; w < lim; w++) begin
          do_reset();
          for (int t = 0; t < w; t++) begin
            do_cmd(2'(k), pw_of(k), "R2 init data ignored");
            do_cmd(2'(k), ~pw_of(k), "R4 wrong");
          end
          do_cmd(2'(k), pw_of(k), "R2 init");
          do_cmd(2'(k), pw_of(k), "R3 match");
        end
      end
    end

    // pairing and single-active behaviour
    ext_trials_ni = 1'b1;
    do_reset();
    do_cmd(2'd0, pw_of(0), "R2 init");
    do_cmd(2'd1, pw_of(1), "R5 other sel re-init");
    do_cmd(2'd1, pw_of(1), "R3 secure match");
    do_cmd(2'd1, pw_of(1), "R5 repeat is init");
    do_cmd(2'd1, pw_of(1), "R3 rematch");
    do_cmd(2'd2, pw_of(2), "R8 new init clears active");
    do_cmd(2'd2, pw_of(2), "R3 match");
    do_cmd(2'd3, pw_of(3), "R8 init", 2);
    do_cmd(2'd3, 24'hFFFFFF, "R8 fail clears");
    do_cmd(2'd0, pw_of(0), "R11 independent");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule